// File: doc/BRIEF.md
# Buffered Compare/Capture Timer-Counter

This block is a timer-counter whose counting length can be 8, 16 or 32 bits. It counts up or down. Each count step comes from one of two tick sources. In timer mode the tick is a divided-down clock enable. In counter mode the tick is a rising edge seen on an external event pin. The counter runs between zero and an end value. That end value is a period register (8-bit width only), channel 0, or the all-ones value of the selected width. When the counter reaches the end of its sequence it wraps or reloads. At that point it emits one-cycle update and overflow pulses and sets a sticky flag.

Two channels sit beside the counter. In compare use, a channel watches the count and pulses a match event when a tick lands on its value. In capture use, a chosen edge on the channel's pin copies the count into the channel. Software never writes a live channel or period value directly. It writes a shadow buffer, which raises a valid bit. The buffer is then moved into the live register at the next update, so a new period or compare value always takes effect on a sequence boundary.

All configuration arrives through a single-cycle register write port. Every output is registered. The block has no streaming data path, so it has no valid/ready pins: every pin is a plain control or status signal.

Top module: `tc_buffered`

## Requirements
- R1: The configuration word is written at address 0. Bits [1:0] select the width: 0 gives 16 bits, 1 gives 8 bits, 2 or 3 give 32 bits. `count_o` never has a bit set above the selected width. Values written to the count or to a buffer are truncated to the width in force at the time of the write.
- R2: When configuration bit 3 is set, TOP is live channel 0. When bit 3 is clear, TOP is the period register in 8-bit width (reset value 255) and all ones of the width otherwise.
- R3: Configuration bit 2 selects down counting. Counting up, a tick at TOP loads zero and any other tick adds one. Counting down, a tick at zero loads TOP and any other tick subtracts one. A tick that wraps or reloads is an update. In the cycle after it, both `ev_update_o` and `ev_ovf_o` pulse high for one cycle, together with the new count.
- R4: Configuration bit 8 enables counting. Bit 7 clear selects timer mode: bits [6:4] = 0..7 divide the clock by 1, 2, 4, 8, 16, 64, 256 or 1024. The divider restarts whenever the configuration is written or counting is disabled. Bit 7 set selects counter mode, where each rising edge of `evt_in` is one tick.
- R5: While bit 8 is clear, the count holds its value unless the count itself is written.
- R6: Writes to address 1 (period, low 8 bits), address 2 (channel 0) and address 3 (channel 1) go to a buffer and set its valid bit. On an update, each buffer whose valid bit is set is copied to its live register, and the valid bit clears. If a buffer write lands in the same cycle as an update, the old buffer is still copied and the valid bit stays set with the new value.
- R7: A channel whose capture bit is clear is in compare mode. When a tick moves the count to a value equal to that channel's live value (as held before the tick), `ev_match_o[i]` pulses one cycle later.
- R8: Configuration bits [10:9] put channel 0 and channel 1 into capture mode. Bit 11 selects the falling edge of `cap_in[i]` instead of the rising edge. On the selected edge, the count held before that clock edge is copied into the live channel. This takes priority over a buffer copy.
- R9: `flags_o` bit 0 is set by an update. Bit 1+i is set by a compare match or a capture on channel i. The flags are sticky. Writing address 4 clears the flags whose data bits are one, and a set in the same cycle wins over the clear.
- R10: A write to address 5 loads the count and takes priority over a tick. After reset the count, the channels, the valid bits, the flags and the configuration are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| evt_in | input | 1 | External event pin, counter-mode tick on rising edge |
| cap_in | input | 2 | Per-channel capture pins |
| count_o | output | 32 | Current count, masked to width |
| ch_o | output | 64 | Live channel values, channel i at [32i+31:32i] |
| bufv_o | output | 2 | Channel buffer valid bits |
| flags_o | output | 3 | Sticky flags: update, channel 0, channel 1 |
| ev_update_o | output | 1 | One-cycle update pulse |
| ev_ovf_o | output | 1 | One-cycle wrap/reload pulse |
| ev_match_o | output | 2 | One-cycle compare match pulses |

## Verification
The hardest cases to reach are a buffer write, a capture edge or a flag clear that falls in the very cycle of an update. Each of these collisions decides whether a valid bit or a flag survives. To make them common, the stimulus uses an 8-bit sequence with a period of a few counts and an undivided tick, so updates arrive every few cycles. Random register writes, event toggles and capture toggles then run on top of it, while a cycle-exact model in the bench is compared on every clock. Separate directed phases cover the 1024 divider, down-count reload to the 32-bit all-ones value, and counting from the event pin.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam logic [2:0] ADDR_CFG = 3'd0;
  localparam logic [2:0] ADDR_PER = 3'd1;
  localparam logic [2:0] ADDR_CH0 = 3'd2;
  localparam logic [2:0] ADDR_CLR = 3'd4;
  localparam logic [2:0] ADDR_CNT = 3'd5;

  typedef struct packed {
    logic       cap_fall;
    logic [1:0] cap_en;
    logic       enable;
    logic       evt_src;
    logic [2:0] psel;
    logic       top_ch0;
    logic       down;
    logic [1:0] wsel;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/tc_prescale.sv
module tc_prescale #(
  parameter int PW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] psel,
  output logic       tick
);
  logic [PW-1:0] div_cnt;
  logic [PW-1:0] limit;

  always_comb begin
    case (psel)
      3'd0:    limit = PW'(0);
      3'd1:    limit = PW'(1);
      3'd2:    limit = PW'(3);
      3'd3:    limit = PW'(7);
      3'd4:    limit = PW'(15);
      3'd5:    limit = PW'(63);
      3'd6:    limit = PW'(255);
      default: limit = PW'(1023);
    endcase
  end

  assign tick = run && (div_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     div_cnt <= '0;
    else if (!run || restart || tick) div_cnt <= '0;
    else                            div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/tc_edge.sv
module tc_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= sig;
  end

  assign rise = sig & ~prev;
  assign fall = ~sig & prev;
endmodule

// File: rtl/tc_channel.sv
module tc_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] mask_i,
  input  logic          wr_buf_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          upd_i,
  input  logic          tick_i,
  input  logic          cmp_mode_i,
  input  logic          cap_hit_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic [CW-1:0] live_o,
  output logic          bufv_o,
  output logic          match_o,
  output logic          flag_set_o
);
  logic [CW-1:0] shadow;
  logic          hit_now;

  assign hit_now    = cmp_mode_i && tick_i && (cnt_nxt_i == live_o);
  assign flag_set_o = hit_now || cap_hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_o  <= '0;
      shadow  <= '0;
      bufv_o  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      match_o <= hit_now;
      if (cap_hit_i)            live_o <= cnt_i;
      else if (upd_i && bufv_o) live_o <= shadow;
      if (wr_buf_i) begin
        shadow <= wr_data_i & mask_i;
        bufv_o <= 1'b1;
      end else if (upd_i) begin
        bufv_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tc_buffered.sv
module tc_buffered #(
  parameter int CW  = 32,
  parameter int NCH = 2,
  parameter int PW  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            evt_in,
  input  logic [1:0]      cap_in,
  output logic [31:0]     count_o,
  output logic [63:0]     ch_o,
  output logic [1:0]      bufv_o,
  output logic [2:0]      flags_o,
  output logic            ev_update_o,
  output logic            ev_ovf_o,
  output logic [1:0]      ev_match_o
);
  import tc_pkg::*;

  localparam int EW = NCH + 1;
  localparam int FW = NCH + 1;

  cfg_t          cfg;
  logic [CW-1:0] cnt, cnt_m, cnt_nxt, mask, top_val;
  logic [7:0]    per, per_buf;
  logic          per_bufv;
  logic          pre_tick, tick, at_end, upd;
  logic [EW-1:0] rise, fall;
  logic [CW-1:0] live [NCH];
  logic [NCH-1:0] ch_set, cap_hit;
  logic [FW-1:0] flags, clr_mask;
  logic          wr_cfg, wr_cnt, wr_per, wr_clr;
  logic          dir_down, run_en;

  assign wr_cfg = wr_en && (wr_addr == ADDR_CFG);
  assign wr_cnt = wr_en && (wr_addr == ADDR_CNT);
  assign wr_per = wr_en && (wr_addr == ADDR_PER);
  assign wr_clr = wr_en && (wr_addr == ADDR_CLR);
  assign dir_down = cfg.down;
  assign run_en   = cfg.enable;

  always_comb begin
    case (cfg.wsel)
      2'd0:    mask = CW'(32'h0000_FFFF);
      2'd1:    mask = CW'(32'h0000_00FF);
      default: mask = '1;
    endcase
  end

  assign cnt_m = cnt & mask;

  always_comb begin
    if (cfg.top_ch0)          top_val = live[0];
    else if (cfg.wsel == 2'd1) top_val = CW'(per);
    else                      top_val = mask;
  end

  tc_prescale #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(cfg.enable), .restart(wr_cfg),
    .psel(cfg.psel), .tick(pre_tick)
  );

  tc_edge #(.W(EW)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig({cap_in, evt_in}), .rise(rise), .fall(fall)
  );

  assign tick   = cfg.enable && (cfg.evt_src ? rise[0] : pre_tick);
  assign at_end = cfg.down ? (cnt_m == '0) : (cnt_m == top_val);
  assign upd    = tick && at_end;

  always_comb begin
    if (cfg.down) cnt_nxt = at_end ? top_val : ((cnt_m - 1'b1) & mask);
    else          cnt_nxt = at_end ? '0      : ((cnt_m + 1'b1) & mask);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cap_hit[i] = cfg.cap_en[i] && (cfg.cap_fall ? fall[i+1] : rise[i+1]);
    tc_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .mask_i(mask),
      .wr_buf_i(wr_en && (wr_addr == ADDR_CH0 + 3'(i))),
      .wr_data_i(wr_data[CW-1:0]), .upd_i(upd), .tick_i(tick),
      .cmp_mode_i(!cfg.cap_en[i]), .cap_hit_i(cap_hit[i]),
      .cnt_i(cnt_m), .cnt_nxt_i(cnt_nxt),
      .live_o(live[i]), .bufv_o(bufv_o[i]), .match_o(ev_match_o[i]),
      .flag_set_o(ch_set[i])
    );
    assign ch_o[32*i +: 32] = 32'(live[i]);
  end

  assign clr_mask = wr_clr ? wr_data[FW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg         <= '0;
      cnt         <= '0;
      per         <= 8'hFF;
      per_buf     <= '0;
      per_bufv    <= 1'b0;
      flags       <= '0;
      ev_update_o <= 1'b0;
      ev_ovf_o    <= 1'b0;
    end else begin
      if (wr_cfg) cfg <= cfg_t'(wr_data[CFG_W-1:0]);
      if (wr_cnt)    cnt <= wr_data[CW-1:0] & mask;
      else if (tick) cnt <= cnt_nxt;
      if (upd && per_bufv) per <= per_buf;
      if (wr_per) begin
        per_buf  <= wr_data[7:0];
        per_bufv <= 1'b1;
      end else if (upd) begin
        per_bufv <= 1'b0;
      end
      flags       <= (flags & ~clr_mask) | {ch_set, upd};
      ev_update_o <= upd;
      ev_ovf_o    <= upd;
    end
  end

  assign count_o = 32'(cnt_m);
  assign flags_o = flags;
endmodule

// File: rtl/tc_buffered_chk.sv
module tc_buffered_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [31:0] count_o,
  input logic [1:0]  bufv_o,
  input logic [2:0]  flags_o,
  input logic        ev_update_o,
  input logic        ev_ovf_o,
  input logic [1:0]  ev_match_o,
  input logic        dir_down,
  input logic        run_en
);
  // R3: an upward update always lands on zero
  a_r3_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_update_o && !$past(dir_down) && !$past(wr_en && wr_addr == 3'd5) |-> count_o == 32'd0);

  // R9: a wrap pulse is always reflected in the sticky flag
  a_r9_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf_o |-> flags_o[0]);

  // R6: an update without a concurrent buffer write leaves channel 0 buffer empty
  a_r6_bufv_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ev_update_o && !$past(wr_en && wr_addr == 3'd2) |-> !bufv_o[0]);

  // R9: a flag stays set unless the clear address is written
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[1] && !(wr_en && wr_addr == 3'd4) |=> flags_o[1]);

  // R7: a match pulse on channel 1 comes with its flag
  a_r7_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match_o[1] |-> flags_o[2]);

  // R5: a disabled counter holds still
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !(wr_en && (wr_addr == 3'd5 || wr_addr == 3'd0)) |=> $stable(count_o));
endmodule

bind tc_buffered tc_buffered_chk u_chk (.*);

// File: tb/test_tc_buffered.sv
module test_tc_buffered;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        evt_in = 1'b0;
  logic [1:0]  cap_in = '0;
  logic [31:0] count_o;
  logic [63:0] ch_o;
  logic [1:0]  bufv_o;
  logic [2:0]  flags_o;
  logic        ev_update_o, ev_ovf_o;
  logic [1:0]  ev_match_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tc_buffered i_tc_buffered (.*);

  // behavioural reference model
  logic [11:0] m_cfg;
  logic [31:0] m_cnt, m_ch [2], m_buf [2], m_per, m_pbuf;
  bit          m_bufv [2], m_pbv, m_evq, m_upd;
  bit [1:0]    m_capq, m_match;
  bit [2:0]    m_flags;
  int          m_pc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_cnt = 0; m_per = 255; m_pbuf = 0; m_pbv = 0;
      m_evq = 0; m_capq = 0; m_upd = 0; m_match = 0; m_flags = 0; m_pc = 0;
      for (int i = 0; i < 2; i++) begin m_ch[i] = 0; m_buf[i] = 0; m_bufv[i] = 0; end
    end else begin
      logic [31:0] msk, top, cm, nx;
      logic [31:0] new_ch [2];
      bit tk, endc, upd, en, ev_mode, down, hit, wcfg;
      bit [2:0] setv;
      int lim;
      en = m_cfg[8]; ev_mode = m_cfg[7]; down = m_cfg[2];
      msk = (m_cfg[1:0] == 0) ? 32'hFFFF : (m_cfg[1:0] == 1) ? 32'hFF : 32'hFFFF_FFFF;
      top = m_cfg[3] ? m_ch[0] : (m_cfg[1:0] == 1) ? m_per : msk;
      lim = (m_cfg[6:4] == 5) ? 63 : (m_cfg[6:4] == 6) ? 255 :
            (m_cfg[6:4] == 7) ? 1023 : (1 << m_cfg[6:4]) - 1;
      hit = en && (m_pc == lim);
      tk = en && (ev_mode ? (evt_in && !m_evq) : hit);
      cm = m_cnt & msk;
      endc = down ? (cm == 0) : (cm == top);
      if (down) nx = endc ? top : ((cm - 1) & msk);
      else      nx = endc ? 0 : ((cm + 1) & msk);
      upd = tk && endc;
      wcfg = wr_en && wr_addr == 0;
      setv = {2'b00, upd};
      for (int i = 0; i < 2; i++) begin
        bit cap, cmp;
        cap = m_cfg[9+i] && (m_cfg[11] ? (!cap_in[i] && m_capq[i]) : (cap_in[i] && !m_capq[i]));
        cmp = !m_cfg[9+i] && tk && (nx == m_ch[i]);
        m_match[i] = cmp;
        if (cap || cmp) setv[i+1] = 1;
        new_ch[i] = cap ? cm : (upd && m_bufv[i]) ? m_buf[i] : m_ch[i];
        if (wr_en && wr_addr == 2 + i) begin m_buf[i] = wr_data & msk; m_bufv[i] = 1; end
        else if (upd) m_bufv[i] = 0;
      end
      m_ch[0] = new_ch[0]; m_ch[1] = new_ch[1];
      if (upd && m_pbv) m_per = m_pbuf;
      if (wr_en && wr_addr == 1) begin m_pbuf = {24'd0, wr_data[7:0]}; m_pbv = 1; end
      else if (upd) m_pbv = 0;
      m_flags = (m_flags & ~((wr_en && wr_addr == 4) ? wr_data[2:0] : 3'd0)) | setv;
      if (wr_en && wr_addr == 5) m_cnt = wr_data & msk;
      else if (tk) m_cnt = nx;
      m_pc = (!en || wcfg || hit) ? 0 : m_pc + 1;
      m_upd = upd; m_evq = evt_in; m_capq = cap_in;
      if (wcfg) m_cfg = wr_data[11:0];
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison: R1/R3 count, R6 channels and valid bits, R9 flags, R7 match
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] msk;
      msk = (m_cfg[1:0] == 0) ? 32'hFFFF : (m_cfg[1:0] == 1) ? 32'hFF : 32'hFFFF_FFFF;
      chk("R3 count", count_o, m_cnt & msk);
      chk("R3 update", {ev_update_o, ev_ovf_o}, {m_upd, m_upd});
      chk("R6 channels", ch_o, {m_ch[1], m_ch[0]});
      chk("R6 bufv", bufv_o, {m_bufv[1], m_bufv[0]});
      chk("R9 flags", flags_o, m_flags);
      chk("R7 match", ev_match_o, m_match);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10 reset count", count_o, 0);
    chk("R10 reset flags", flags_o, 0);
    chk("R10 reset bufv", bufv_o, 0);
    chk("R10 reset channels", ch_o, 0);
    // R6: buffered writes, R10 count load, R3/R1 16-bit wrap at MAX, R2 TOP = MAX
    wr(3'd2, 32'd3);
    wr(3'd3, 32'd7);
    wr(3'd5, 32'h1_FFFD);        // R1: truncated to 16 bits
    wr(3'd0, 32'h100);           // enable, 16-bit, up, divide by 1
    idle(20);
    chk("R6 live after update", ch_o, {32'd7, 32'd3});
    // R2: 8-bit with period buffer; first wrap at 255 loads period 9
    wr(3'd1, 32'd9);
    wr(3'd0, 32'h101);
    idle(300);
    // R9: clear all flags
    wr(3'd4, 32'd7);
    // R2/R3: TOP from channel 0, down counting, R4 divide by 4
    wr(3'd2, 32'd6);
    wr(3'd0, 32'h12D);
    idle(120);
    // R4: divide by 1024, 64, 256 and by 2
    wr(3'd0, 32'h170);
    idle(2300);
    wr(3'd0, 32'h150);
    idle(200);
    wr(3'd0, 32'h160);
    idle(600);
    wr(3'd0, 32'h110);
    idle(30);
    // R4: counter mode, 32-bit down from 1: reload to all ones (R1/R3)
    wr(3'd5, 32'd1);
    wr(3'd0, 32'h186);
    for (int i = 0; i < 12; i++) begin
      evt_in = 1; idle(1 + (i % 3));
      evt_in = 0; idle(2 + (i % 2));
    end
    // R5: disable, count holds while events and ticks arrive
    wr(3'd0, 32'h082);
    for (int i = 0; i < 4; i++) begin evt_in = 1; idle(2); evt_in = 0; idle(2); end
    // R8: capture on both channels, rising then falling edge
    wr(3'd0, 32'h601);
    for (int i = 0; i < 6; i++) begin cap_in = 2'(i + 1); idle(5); end
    wr(3'd0, 32'hE01);
    for (int i = 0; i < 6; i++) begin cap_in = 2'(i); idle(4); end
    // random phase: short 8-bit periods, collisions of writes with updates
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h101);
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      evt_in = 1'($urandom);
      cap_in = 2'($urandom);
      wr_en = ($urandom % 3) == 0;
      wr_addr = 3'($urandom % 6);
      wr_data = $urandom % 12;
      if (wr_en && wr_addr == 0) wr_data = ($urandom & 32'hEFF) | 32'h100;
      if (wr_en && wr_addr == 0 && ($urandom % 2)) wr_data[1:0] = 2'd1;
    end
    wr_en = 0;
    idle(5);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule